// File: doc/BRIEF.md
# Segmented Tapped Wide Delay Line

This block delays a wide data word by a fixed number of accepted shifts. The pipe is a cascade of equal shift segments, each `SEG_LEN` positions deep, with one boundary register after every segment. Each segment has an addressable read tap. The main path reads each segment one position short of its end, so that segment plus its boundary register adds exactly `SEG_LEN` shifts, and the whole pipe delays by `SEGS*SEG_LEN`. Positions inside a segment are reachable only through the tap address. The boundary registers and the tap read are the only points where the pipe can be observed.

Besides the fully delayed word, the block gives two tapped words. The first is the input column, which is the word accepted on the most recent shift. The second is a diagonal tap with one bit per lane. Lanes are grouped in `GRP_LANES`. Group `g` reads the depth `tap_sel + g`, wrapped around the total depth, so the groups step one position deeper each. The tap code is registered once per lane group, which keeps its fanout small. The resulting segment and position select the bit. The nominal build is 384 lanes by 64 shifts, set through the parameters.

Every storage stage advances only on `shift_en`. A synchronous reset clears the whole pipe, so outputs read zero until real data has moved far enough in.

Top module: `tapped_delay_line`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every stage. From the next cycle, `dout`, `col_out` and `tap_out` read all-zero. `dout` stays zero until `SEGS*SEG_LEN` shifts have been accepted after the reset.
- R2: After a clock edge with `shift_en` high, `dout` equals the word on `din` at the accepted shift exactly `SEGS*SEG_LEN` shifts earlier. The boundary registers are included in that count.
- R3: A clock edge with `shift_en` low changes no stage. `dout` and `col_out` keep their values, and later outputs show the stored words unchanged.
- R4: After a clock edge with `shift_en` high, `col_out` equals the `din` value taken at that edge.
- R5: Lane `i` belongs to group `g = i / GRP_LANES`. With code `c = (tap_sel + g) mod (SEGS*SEG_LEN)`, `tap_out[i]` equals bit `i` of the word accepted `c+1` shifts ago. The code splits into segment `c / SEG_LEN` and position `c mod SEG_LEN`. This holds once `tap_sel` has been steady for two clock edges with no shift in between.
- R6: The group codes wrap. When `tap_sel + g` reaches `SEGS*SEG_LEN`, that group reads depth 1 again.
- R7: A depth that is a multiple of `SEG_LEN` reads the last position of a segment. That position is one shift deeper than the main path's read point. A depth one greater reads the first position of the next segment.
- R8: A new `tap_sel` value takes effect at `tap_out` after exactly two rising edges. After the first edge, `tap_out` still shows the old selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Accept `din` and advance every stage |
| din | input | LANES | Input word |
| tap_sel | input | $clog2(SEGS*SEG_LEN) | Base code of the diagonal tap (code c reads depth c+1) |
| dout | output | LANES | Word delayed by SEGS*SEG_LEN shifts |
| col_out | output | LANES | Input column: most recently accepted word |
| tap_out | output | LANES | Diagonal tap, one bit per lane |

## Verification
The bench builds the block with 16 lanes in four groups of four, with four segments of 16. The depth of 64 is the nominal one, so every segment, every boundary register and the full fill time are exercised. Four groups make the diagonal step across segment edges when `tap_sel` sits just below a multiple of 16. The same four groups make it wrap from depth 64 back to depth 1 near the top code. Random runs with gaps in `shift_en` are mixed with directed codes at the edges, a mid-run reset and a change of tap code while the pipe is idle.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  // Depth code for one lane group: base code plus group index, wrapped to the pipe depth.
  function automatic int wrap_sum(input int base, input int grp, input int total);
    return (base + grp) % total;
  endfunction

endpackage

// File: rtl/tdl_segment.sv
module tdl_segment #(
  parameter int LANES   = 32,
  parameter int SEG_LEN = 16,
  localparam int AW     = $clog2(SEG_LEN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [LANES-1:0]          seg_in,
  input  logic [AW-1:0]             main_addr,
  input  logic [LANES-1:0][AW-1:0]  lane_addr,
  output logic [LANES-1:0]          main_out,
  output logic [LANES-1:0]          lane_out
);

  // Position j holds the word accepted j+1 shifts ago.
  logic [SEG_LEN-1:0][LANES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (en) begin
      sr[0] <= seg_in;
      for (int j = 1; j < SEG_LEN; j++) sr[j] <= sr[j-1];
    end
  end

  assign main_out = sr[main_addr];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_out[i] = sr[lane_addr[i]][i];
  end

endmodule

// File: rtl/tdl_tap_ctrl.sv
module tdl_tap_ctrl #(
  parameter int GROUPS = 4,
  parameter int TOTAL  = 64,
  localparam int DW    = $clog2(TOTAL)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DW-1:0]              tap_sel,
  output logic [GROUPS-1:0][DW-1:0]  grp_code
);

  // One registered copy of the depth code per lane group keeps fanout bounded.
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) grp_code[g] <= '0;
      else     grp_code[g] <= DW'(tdl_pkg::wrap_sum(int'(tap_sel), g, TOTAL));
    end
  end

endmodule

// File: rtl/tapped_delay_line.sv
module tapped_delay_line #(
  parameter int LANES     = 32,
  parameter int SEG_LEN   = 16,
  parameter int SEGS      = 4,
  parameter int GRP_LANES = 8,
  localparam int TOTAL    = SEGS * SEG_LEN,
  localparam int DW       = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [LANES-1:0] din,
  input  logic [DW-1:0]    tap_sel,
  output logic [LANES-1:0] dout,
  output logic [LANES-1:0] col_out,
  output logic [LANES-1:0] tap_out
);

  localparam int AW     = $clog2(SEG_LEN);
  localparam int SW     = DW - AW;
  localparam int GROUPS = (LANES + GRP_LANES - 1) / GRP_LANES;
  // Segment read point plus boundary register spans SEG_LEN shifts.
  localparam logic [AW-1:0] MAIN_ADDR = AW'(SEG_LEN - 2);

  logic [SEGS-1:0][LANES-1:0]  bnd;
  logic [SEGS-1:0][LANES-1:0]  seg_main;
  logic [SEGS-1:0][LANES-1:0]  seg_lane;
  logic [GROUPS-1:0][DW-1:0]   grp_code;
  logic [LANES-1:0][AW-1:0]    lane_addr;
  logic [LANES-1:0][SW-1:0]    lane_seg;
  logic [LANES-1:0]            tap_next;
  logic [LANES-1:0]            col_q;
  logic [LANES-1:0]            tap_q;

  tdl_tap_ctrl #(.GROUPS(GROUPS), .TOTAL(TOTAL)) u_tap_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tap_sel  (tap_sel),
    .grp_code (grp_code)
  );

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic [LANES-1:0] seg_src;
    if (s == 0) begin : g_head
      assign seg_src = din;
    end else begin : g_body
      assign seg_src = bnd[s-1];
    end

    tdl_segment #(.LANES(LANES), .SEG_LEN(SEG_LEN)) u_seg (
      .clk       (clk),
      .rst       (rst),
      .en        (shift_en),
      .seg_in    (seg_src),
      .main_addr (MAIN_ADDR),
      .lane_addr (lane_addr),
      .main_out  (seg_main[s]),
      .lane_out  (seg_lane[s])
    );

    always_ff @(posedge clk) begin
      if (rst)           bnd[s] <= '0;
      else if (shift_en) bnd[s] <= seg_main[s];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int G = i / GRP_LANES;
    assign lane_addr[i] = grp_code[G][AW-1:0];
    assign lane_seg[i]  = grp_code[G][DW-1:AW];
    assign tap_next[i]  = seg_lane[lane_seg[i]][i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      tap_q <= '0;
    end else begin
      if (shift_en) col_q <= din;
      tap_q <= tap_next;
    end
  end

  assign dout    = bnd[SEGS-1];
  assign col_out = col_q;
  assign tap_out = tap_q;

endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_en,
  input logic [LANES-1:0] din,
  input logic [LANES-1:0] dout,
  input logic [LANES-1:0] col_out,
  input logic [LANES-1:0] tap_out,
  input logic [LANES-1:0] last_main
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == '0 && col_out == '0 && tap_out == '0)); // R1

  AST_LAST_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> dout == $past(last_main)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ($stable(dout) && $stable(col_out))); // R3

  AST_COL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> col_out == $past(din)); // R4

endmodule

bind tapped_delay_line tdl_checker #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_en  (shift_en),
  .din       (din),
  .dout      (dout),
  .col_out   (col_out),
  .tap_out   (tap_out),
  .last_main (seg_main[SEGS-1])
);

// File: tb/tapped_delay_line_tb.sv
module tapped_delay_line_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 16;
  localparam int SEG_LEN    = 16;
  localparam int SEGS       = 4;
  localparam int GRP_LANES  = 4;
  localparam int TOTAL      = SEGS * SEG_LEN;
  localparam int DW         = $clog2(TOTAL);
  localparam int HMAX       = 8192;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             shift_en = 1'b0;
  logic [LANES-1:0] din = '0;
  logic [DW-1:0]    tap_sel = '0;
  logic [LANES-1:0] dout, col_out, tap_out;

  int checks = 0;
  int errors = 0;
  int n      = 0;
  bit done   = 1'b0;
  logic [LANES-1:0] hist [0:HMAX-1];

  tapped_delay_line #(
    .LANES(LANES), .SEG_LEN(SEG_LEN), .SEGS(SEGS), .GRP_LANES(GRP_LANES)
  ) u_dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(din), .tap_sel(tap_sel),
    .dout(dout), .col_out(col_out), .tap_out(tap_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [LANES-1:0] word_at(input int d);
    return (n >= d) ? hist[n-d] : '0;
  endfunction

  function automatic logic [LANES-1:0] tap_expect(input int sel);
    logic [LANES-1:0] e;
    for (int i = 0; i < LANES; i++) begin
      logic [LANES-1:0] w;
      w    = word_at(((sel + i / GRP_LANES) % TOTAL) + 1);
      e[i] = w[i];
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic [LANES-1:0] d);
    shift_en = en;
    din      = d;
    @(posedge clk);
    if (en && n < HMAX) begin
      hist[n] = d;
      n++;
    end
    @(negedge clk);
    if (!en)            chk("R3", "dout idle", dout, word_at(TOTAL));
    else if (n < TOTAL) chk("R1", "dout fill", dout, word_at(TOTAL));
    else                chk("R2", "dout", dout, word_at(TOTAL));
    chk(en ? "R4" : "R3", "col_out", col_out, word_at(1));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    shift_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n = 0;
    chk("R1", "dout reset", dout, '0);
    chk("R1", "col_out reset", col_out, '0);
    chk("R1", "tap_out reset", tap_out, '0);
  endtask

  task automatic check_taps(input int sel, input string tag);
    tap_sel = DW'(sel);
    cyc(1'b0, '0);
    cyc(1'b0, '0);
    chk(tag, $sformatf("tap_out sel=%0d", sel), tap_out, tap_expect(sel));
  endtask

  task automatic run(input int cnt, input int pct);
    for (int k = 0; k < cnt; k++)
      cyc(($urandom % 100) < pct, LANES'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();                        // R1 reset state
    run(40, 100);                      // R1 pipe still filling
    check_taps(0, "R5");
    check_taps(10, "R5");
    run(120, 70);                      // R2 with gaps, R3
    check_taps(15, "R7");              // groups cross into segment 1
    check_taps(31, "R7");
    check_taps(47, "R7");
    check_taps(62, "R6");              // depths 63,64,1,2
    check_taps(63, "R6");              // depths 64,1,2,3
    for (int r = 0; r < 20; r++) begin
      run(8 + ($urandom % 24), 75);
      check_taps(int'($urandom % TOTAL), "R5");
    end
    // R8: new code visible after exactly two edges
    check_taps(5, "R8");
    tap_sel = DW'(40);
    cyc(1'b0, '0);
    chk("R8", "tap_out one edge after change", tap_out, tap_expect(5));
    cyc(1'b0, '0);
    chk("R8", "tap_out two edges after change", tap_out, tap_expect(40));
    // R3: idle stretch then confirm stored contents at every tap
    run(10, 0);
    check_taps(20, "R3");
    // R1: mid-run reset, then fill shorter than the depth
    do_reset();
    run(TOTAL - 1, 100);
    check_taps(50, "R1");
    run(3, 100);                       // R2 first real data at dout
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule